// File: doc/BRIEF.md
# Fast Ethernet PCS transmit path

This block turns the 4-bit transmit nibbles of a media-independent interface into the three-level MLT-3 symbol stream of a 100 Mb/s twisted-pair link. It runs on the 125 MHz symbol clock. Every fifth clock it samples one nibble, builds a 5-bit code group, and then emits that group one bit per clock. In normal mode the nibble goes through the 4B/5B map and the framing logic (idle fill, start and end delimiters). Each serial bit is then XORed with an 11-bit scrambler key before the MLT-3 encoder uses it.

A bypass mode takes a 5-bit word that is already scrambled straight from the interface pins: tx_er is the MSB and txd the low four bits. The word goes to the serializer and the encoder without mapping or scrambling, and the frame-enable input is ignored. Bypass is requested by a pin or by a configuration bit. The request counts only while auto-negotiation is off.

The surrounding logic presents a nibble while `nib_rdy` is high. The block takes it on that clock edge.

Top module: `pcs_tx_path`

## Requirements
- R1: While reset is high, and at the first clock after reset, `line_lvl` is 0 (2'b00) and `nib_rdy` is 1.
- R2: `nib_rdy` is high on exactly one clock in five. The inputs tx_en, tx_er, txd, byp_pin, byp_cfg and autoneg_off are sampled only on the rising edge that ends a high `nib_rdy` cycle.
- R3: In normal mode, inside a frame, with tx_er low, each data nibble is sent as its standard 4B/5B group (0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101).
- R4: In normal mode, outside a frame, with tx_en low, the idle group 11111 is sent.
- R5: When tx_en is first seen high outside a frame, that nibble and the next one are replaced by J (11000) and then K (10001). Data mapping starts with the third nibble, whatever tx_en is on the second.
- R6: When tx_en is seen low inside a frame, T (01101) and then R (00111) are sent, after which the framing returns to idle. tx_er high during data sends the error group 00100 in place of the nibble.
- R7: The scrambler is an 11-bit register seeded all-ones by reset. On every clock, key = s[10]^s[8] and s becomes {s[9:0], key}, in every mode. In normal mode each serial bit is XORed with the key of its clock.
- R8: Code groups are sent MSB first. The first bit of a group taken at edge k reaches the encoder at edge k+1, and the fifth bit at edge k+5.
- R9: The MLT-3 encoder steps through the level cycle 0, +1, 0, −1 on each serial 1 and holds its level on each serial 0. `line_lvl` is signed: +1 = 2'b01, 0 = 2'b00, −1 = 2'b11. The value 2'b10 never appears.
- R10: Bypass is in effect when autoneg_off is high and either byp_pin or byp_cfg is high. The group is then {tx_er, txd[3:0]}, sent unscrambled, tx_en is ignored, and the framing state is set to idle.
- R11: With autoneg_off low, byp_pin and byp_cfg have no effect and the block behaves as in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz symbol clock |
| rst | input | 1 | synchronous active-high reset |
| tx_en | input | 1 | frame enable from the MAC |
| tx_er | input | 1 | transmit error, or code MSB in bypass |
| txd | input | 4 | transmit nibble, or code low bits in bypass |
| byp_pin | input | 1 | bypass request from a pin |
| byp_cfg | input | 1 | bypass request from a configuration bit |
| autoneg_off | input | 1 | high while auto-negotiation is disabled |
| nib_rdy | output | 1 | the current edge samples the inputs |
| line_lvl | output | 2 | signed MLT-3 level (+1, 0, −1) |

## Verification
Assertions watch the invariants that hold on every cycle:
- the 1-in-5 cadence of `nib_rdy` and the phase range;
- a scrambler state that never becomes zero;
- the MLT-3 hold and step rule and the absence of the unused level code;
- the K state being entered only from idle;
- scrambling being on for normal-mode groups and off for bypass groups, including the case where auto-negotiation overrides the bypass request.

Only the bench scenarios can show that the bit sequence on the line is right: the 4B/5B values, the J/K and T/R placement, the MSB-first order, the scrambler key stream and the bypass words. The bench shows this by matching `line_lvl` on every cycle against its own model, through idle gaps, random frames with errors, and both bypass sources, with auto-negotiation on and off.

// File: rtl/pcs_tx_pkg.sv
package pcs_tx_pkg;
  localparam int NIB_W  = 4;
  localparam int CODE_W = 5;

  typedef enum logic [1:0] {FS_IDLE, FS_K, FS_DATA, FS_R} frm_st_t;

  localparam logic [CODE_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [CODE_W-1:0] CG_J    = 5'b11000;
  localparam logic [CODE_W-1:0] CG_K    = 5'b10001;
  localparam logic [CODE_W-1:0] CG_T    = 5'b01101;
  localparam logic [CODE_W-1:0] CG_R    = 5'b00111;
  localparam logic [CODE_W-1:0] CG_H    = 5'b00100;

  function automatic logic [CODE_W-1:0] map_nib(input logic [NIB_W-1:0] n);
    logic [CODE_W-1:0] c;
    case (n)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/pcs_tx_encoder.sv
module pcs_tx_encoder
  import pcs_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              byp,
  input  logic              tx_en,
  input  logic              tx_er,
  input  logic [NIB_W-1:0]  txd,
  output logic [CODE_W-1:0] code,
  output logic              scr_en
);
  frm_st_t st, st_nxt;

  always_comb begin
    st_nxt = st;
    code   = CG_IDLE;
    scr_en = 1'b1;
    if (byp) begin
      code   = {tx_er, txd};
      scr_en = 1'b0;
      st_nxt = FS_IDLE;
    end else begin
      case (st)
        FS_IDLE: begin
          if (tx_en) begin
            code   = CG_J;
            st_nxt = FS_K;
          end
        end
        FS_K: begin
          code   = CG_K;
          st_nxt = FS_DATA;
        end
        FS_DATA: begin
          if (!tx_en) begin
            code   = CG_T;
            st_nxt = FS_R;
          end else if (tx_er) begin
            code = CG_H;
          end else begin
            code = map_nib(txd);
          end
        end
        default: begin
          code   = CG_R;
          st_nxt = FS_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       st <= FS_IDLE;
    else if (load) st <= st_nxt;
  end

  // R5: the K state is only ever entered from idle
  p_k_from_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (load && !byp && st == FS_IDLE && tx_en) |=> (st == FS_K));
  p_k_entry_r5: assert property (@(posedge clk) disable iff (rst)
    (st == FS_K && $past(st) != FS_K) |-> ($past(st) == FS_IDLE));
  // R6: R always follows T and is left after one group
  p_r_exit_r6: assert property (@(posedge clk) disable iff (rst)
    (load && !byp && st == FS_R) |=> (st == FS_IDLE));
endmodule

// File: rtl/pcs_tx_scrambler.sv
module pcs_tx_scrambler #(
  parameter int LFSR_W = 11,
  parameter int TAP    = 9
) (
  input  logic clk,
  input  logic rst,
  output logic key
);
  logic [LFSR_W-1:0] s;

  assign key = s[LFSR_W-1] ^ s[TAP-1];

  always_ff @(posedge clk) begin
    if (rst) s <= '1;
    else     s <= {s[LFSR_W-2:0], key};
  end

  // R7: a nonzero seed never collapses to the all-zero lock-up state
  p_lfsr_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
    s != '0);
endmodule

// File: rtl/pcs_tx_serializer.sv
module pcs_tx_serializer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] code_in,
  input  logic         scr_in,
  output logic         load,
  output logic         ser_bit,
  output logic         ser_scr
);
  localparam int PH_W = $clog2(W);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(W - 1);

  logic [PH_W-1:0] phase;
  logic [W-1:0]    sh;
  logic            rdy_q;
  logic            scr_q;

  assign load    = rdy_q;
  assign ser_bit = sh[W-1];
  assign ser_scr = scr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      rdy_q <= 1'b1;
      sh    <= '0;
      scr_q <= 1'b0;
    end else begin
      phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
      rdy_q <= (phase == PH_LAST);
      if (rdy_q) begin
        sh    <= code_in;
        scr_q <= scr_in;
      end else begin
        sh <= {sh[W-2:0], 1'b0};
      end
    end
  end

  // R2: phase stays in range and a load is followed by W-1 idle slots
  p_phase_range_r2: assert property (@(posedge clk) disable iff (rst)
    phase <= PH_LAST);
  p_rdy_gap_r2: assert property (@(posedge clk) disable iff (rst)
    rdy_q |=> !rdy_q);
  p_rdy_phase_r2: assert property (@(posedge clk) disable iff (rst)
    rdy_q |-> (phase == '0));
endmodule

// File: rtl/pcs_tx_mlt3.sv
module pcs_tx_mlt3 (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_in,
  output logic signed [1:0] lvl
);
  logic [1:0] idx;
  logic [1:0] idx_nxt;

  assign idx_nxt = bit_in ? idx + 2'd1 : idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= 2'd0;
      lvl <= 2'sd0;
    end else begin
      idx <= idx_nxt;
      case (idx_nxt)
        2'd1:    lvl <= 2'sb01;
        2'd3:    lvl <= 2'sb11;
        default: lvl <= 2'sb00;
      endcase
    end
  end

  // R9: hold on a zero, step on a one, unused code never driven
  p_hold_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !bit_in |=> $stable(lvl));
  p_step_one_r9: assert property (@(posedge clk) disable iff (rst)
    bit_in |=> (lvl != $past(lvl)));
  p_legal_lvl_r9: assert property (@(posedge clk) disable iff (rst)
    lvl != 2'sb10);
endmodule

// File: rtl/pcs_tx_path.sv
module pcs_tx_path
  import pcs_tx_pkg::*;
#(
  parameter int LFSR_W = 11,
  parameter int TAP    = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              tx_er,
  input  logic [3:0]        txd,
  input  logic              byp_pin,
  input  logic              byp_cfg,
  input  logic              autoneg_off,
  output logic              nib_rdy,
  output logic signed [1:0] line_lvl
);
  logic              byp;
  logic              load;
  logic [CODE_W-1:0] code;
  logic              scr_en;
  logic              ser_bit;
  logic              ser_scr;
  logic              key;
  logic              line_bit;

  assign byp      = autoneg_off & (byp_pin | byp_cfg);
  assign nib_rdy  = load;
  assign line_bit = ser_bit ^ (ser_scr & key);

  pcs_tx_encoder u_enc (
    .clk(clk), .rst(rst), .load(load), .byp(byp),
    .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
    .code(code), .scr_en(scr_en)
  );

  pcs_tx_serializer #(.W(CODE_W)) u_ser (
    .clk(clk), .rst(rst), .code_in(code), .scr_in(scr_en),
    .load(load), .ser_bit(ser_bit), .ser_scr(ser_scr)
  );

  pcs_tx_scrambler #(.LFSR_W(LFSR_W), .TAP(TAP)) u_scr (
    .clk(clk), .rst(rst), .key(key)
  );

  pcs_tx_mlt3 u_mlt (
    .clk(clk), .rst(rst), .bit_in(line_bit), .lvl(line_lvl)
  );

  // R10: a bypass group is sent without scrambling
  p_bypass_raw_r10: assert property (@(posedge clk) disable iff (rst)
    (load && autoneg_off && (byp_pin || byp_cfg)) |=> !ser_scr);
  // R11: without autoneg_off the bypass request is ignored
  p_anoff_gate_r11: assert property (@(posedge clk) disable iff (rst)
    (load && !autoneg_off) |=> ser_scr);
endmodule

// File: tb/test_pcs_tx_path.sv
module test_pcs_tx_path;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tx_en = 1'b0;
  logic              tx_er = 1'b0;
  logic [3:0]        txd = 4'h0;
  logic              byp_pin = 1'b0;
  logic              byp_cfg = 1'b0;
  logic              autoneg_off = 1'b0;
  logic              nib_rdy;
  logic signed [1:0] line_lvl;

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pcs_tx_path i_pcs_tx_path (
    .clk(clk), .rst(rst), .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
    .byp_pin(byp_pin), .byp_cfg(byp_cfg), .autoneg_off(autoneg_off),
    .nib_rdy(nib_rdy), .line_lvl(line_lvl)
  );

  // reference model, built from the requirements
  function automatic logic [4:0] ref_map(input logic [3:0] n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                           5'b01010, 5'b01011, 5'b01110, 5'b01111,
                           5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  function automatic logic signed [1:0] ref_lvl(input logic [1:0] i);
    return (i == 2'd1) ? 2'sb01 : (i == 2'd3) ? 2'sb11 : 2'sb00;
  endfunction

  logic [10:0] m_lfsr;
  logic [4:0]  m_sh;
  logic        m_scr;
  int          m_ph;
  logic [1:0]  m_idx;
  int          m_fs;      // 0 idle, 1 K next, 2 data, 3 R next

  always @(posedge clk) begin
    if (rst) begin
      m_lfsr = '1; m_sh = '0; m_scr = 1'b0; m_ph = 0; m_idx = 2'd0; m_fs = 0;
    end else begin
      logic k, b, bp;
      logic [4:0] c;
      k = m_lfsr[10] ^ m_lfsr[8];
      b = m_sh[4] ^ (m_scr & k);
      m_lfsr = {m_lfsr[9:0], k};
      if (b) m_idx = m_idx + 2'd1;
      if (m_ph == 0) begin
        bp = autoneg_off && (byp_pin || byp_cfg);
        if (bp) begin
          c = {tx_er, txd}; m_scr = 1'b0; m_fs = 0;
        end else begin
          m_scr = 1'b1;
          case (m_fs)
            0: if (tx_en) begin c = 5'b11000; m_fs = 1; end else c = 5'b11111;
            1: begin c = 5'b10001; m_fs = 2; end
            2: if (!tx_en) begin c = 5'b01101; m_fs = 3; end
               else c = tx_er ? 5'b00100 : ref_map(txd);
            default: begin c = 5'b00111; m_fs = 0; end
          endcase
        end
        m_sh = c;
      end else begin
        m_sh = {m_sh[3:0], 1'b0};
      end
      m_ph = (m_ph == 4) ? 0 : m_ph + 1;
    end
  end

  task automatic chk(input string req, input int got, input int exp, input string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(tag, int'(line_lvl), int'(ref_lvl(m_idx)), "line_lvl");
      chk("R2", int'(nib_rdy), int'(m_ph == 0), "nib_rdy");
    end
  end

  task automatic next_slot();
    @(negedge clk);
    while (!nib_rdy) @(negedge clk);
  endtask

  task automatic send(input logic en, input logic er, input logic [3:0] d);
    next_slot();
    tx_en = en; tx_er = er; txd = d;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", int'(line_lvl), 0, "line_lvl in reset");
    chk("R1", int'(nib_rdy), 1, "nib_rdy in reset");
    rst = 1'b0;
    @(negedge clk);
    chk("R1", int'(nib_rdy), 0, "nib_rdy one cycle after reset");

    // R4 / R7 / R8: idle fill, scrambled, MSB first
    tag = "R4";
    repeat (8) send(1'b0, 1'b0, 4'h0);
    // R5 / R3 / R6: directed frame with all nibble values
    tag = "R5";
    send(1'b1, 1'b0, 4'h5);
    send(1'b0, 1'b0, 4'h5);          // K sent even though tx_en is low
    tag = "R3";
    for (int i = 0; i < 16; i++) send(1'b1, 1'b0, 4'(i));
    tag = "R6";
    send(1'b1, 1'b1, 4'h3);
    send(1'b0, 1'b0, 4'h0);
    send(1'b0, 1'b0, 4'h0);
    repeat (3) send(1'b0, 1'b0, 4'h0);

    // R3 / R6 / R7 / R8: random frames and gaps
    tag = "R7";
    for (int f = 0; f < 40; f++) begin
      int len = 3 + int'($urandom_range(0, 20));
      for (int n = 0; n < len; n++)
        send(1'b1, ($urandom_range(0, 15) == 0), 4'($urandom));
      repeat (1 + $urandom_range(0, 4)) send(1'b0, 1'($urandom), 4'($urandom));
    end

    // R10: bypass through the pin, then the config bit, tx_en random
    tag = "R10";
    autoneg_off = 1'b1;
    send(1'b1, 1'b0, 4'h1);          // open a frame, then bypass cuts it
    byp_pin = 1'b1;
    for (int n = 0; n < 60; n++) send(1'($urandom), 1'($urandom), 4'($urandom));
    byp_pin = 1'b0; byp_cfg = 1'b1;
    send(1'b1, 1'b1, 4'hF);
    send(1'b0, 1'b0, 4'h0);
    for (int n = 0; n < 60; n++) send(1'($urandom), 1'($urandom), 4'($urandom));
    byp_cfg = 1'b0;
    tag = "R5";
    for (int n = 0; n < 30; n++) send(n < 25, 1'b0, 4'($urandom));

    // R11: bypass requests with auto-negotiation active
    tag = "R11";
    autoneg_off = 1'b0; byp_pin = 1'b1; byp_cfg = 1'b1;
    for (int f = 0; f < 10; f++) begin
      for (int n = 0; n < 12; n++) send(1'b1, 1'b0, 4'($urandom));
      repeat (3) send(1'b0, 1'b1, 4'($urandom));
    end
    // R9: long run of alternating inputs in bypass for many level steps
    tag = "R9";
    autoneg_off = 1'b1;
    for (int n = 0; n < 40; n++) send(1'b0, 1'($urandom), 4'($urandom));
    byp_pin = 1'b0; byp_cfg = 1'b0;
    repeat (6) send(1'b0, 1'b0, 4'h0);
    next_slot();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule